// File: doc/BRIEF.md
# Windowed IF Frequency Counter

This block decides whether an intermediate-frequency signal sits close enough to its nominal value for a tuner's automatic search to halt on the current station. It opens a gate of programmable length and loads a down counter with the number of IF edges a perfectly centred signal would produce in that gate. It then decrements the counter on every IF pulse. When the gate closes, the remaining count is compared against a tolerance, and a stop flag reports the pass or fail verdict for the measurement just finished.

The gate timebase is the reference clock divided by a programmable integer. A binary stage then stretches it by a power of two that the sample-time code selects. The nominal count comes from a per-mode base plus a 5-bit center trim, scaled by the same power of two. The tolerance is a power of two picked by a 3-bit window code. Measurements run back to back while the block is enabled in a valid mode. Any change to the mode, window, sample-time or center code abandons the gate in progress and starts a new one. The IF input is a pulse stream already synchronized to the reference clock, with one high cycle per IF edge.

Top module: `ifc_window_counter`

## Requirements
- R1: While `enable` is low or `mode` is 00, the block is idle. From the next clock edge `meas_done` and `stop_flag` stay low and no measurement runs.
- R2: A gate lasts G = (`tim_div`+1)·2^k reference cycles, where k = 7 − `smp_code`. Code 111 therefore gives the shortest gate and 000 the longest. A new gate begins on the first edge at which the block is active, and gates then follow each other with no gap.
- R3: The nominal count is (B + `ctr_code`)·2^k. B is FM_BASE (default 1696) for mode 01, AM_BASE (default 448) for mode 10, and UPC_BASE (default 10688) for mode 11.
- R4: Let D be the nominal count minus the number of IF pulses sampled during the gate. For `win_code` w in 3..7 the stop flag is set when |D| ≤ 2^(k+w−3), inclusive at both ends. Otherwise it is cleared.
- R5: `win_code` values 000, 001 and 010 never produce a high stop flag.
- R6: `stop_flag` and a one-cycle `meas_done` pulse update on the edge that closes a gate. The flag then keeps its value until the next gate closes.
- R7: A change of `mode`, `win_code`, `smp_code` or `ctr_code` while active aborts the gate in progress. The change clears `stop_flag` on the next edge, and the next `meas_done` comes a full G cycles after that edge.
- R8: During and right after reset, `stop_flag` and `meas_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counter enable; low means standby |
| mode | input | 2 | 01 FM, 10 AM, 11 AM up-conversion, 00 idle |
| tim_div | input | DIV_W (14) | Timebase divider value; divides by value + 1 |
| win_code | input | 3 | Tolerance window select |
| smp_code | input | 3 | Sample-time select |
| ctr_code | input | 5 | Center-frequency trim |
| if_pulse | input | 1 | Synchronized IF edge pulse |
| stop_flag | output | 1 | Verdict of the last finished measurement |
| meas_done | output | 1 | One-cycle strobe at each gate close |

## Verification
Both results are registered on the edge that closes a gate. When inputs change at a falling edge, the first strobe therefore appears at the falling edge G+1 cycles later, and each following strobe comes G cycles after the previous one. The bench counts falling edges between strobes to check the gate length. It reads the verdict at the same falling edge where it sees the strobe. Its IF pattern repeats every `tim_div`+1 cycles, so every gate holds an exact, known pulse count wherever the gate starts. After a change to the stimulus, the bench discards the first strobe, because that gate may mix old and new input, and judges only the second.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int MODE_W   = 2;
  localparam int CODE_W   = 3;
  localparam int CTR_W    = 5;
  localparam int GLOG_MAX = (1 << CODE_W) - 1;
  localparam int WIN_MIN  = 3;

  typedef enum logic [MODE_W-1:0] {
    IFM_OFF = 2'b00,
    IFM_FM  = 2'b01,
    IFM_AM  = 2'b10,
    IFM_UPC = 2'b11
  } ifc_mode_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [CODE_W-1:0] win;
    logic [CODE_W-1:0] smp;
    logic [CTR_W-1:0]  ctr;
  } ifc_cfg_t;

  // log2 of the gate length in timebase ticks
  function automatic int gate_log(input logic [CODE_W-1:0] smp);
    return GLOG_MAX - int'(smp);
  endfunction

  function automatic int mode_base(input logic [MODE_W-1:0] m,
                                   input int fmb, input int amb, input int upcb);
    case (m)
      IFM_FM:  return fmb;
      IFM_AM:  return amb;
      IFM_UPC: return upcb;
      default: return 0;
    endcase
  endfunction

  function automatic int expected_count(input ifc_cfg_t c,
                                        input int fmb, input int amb, input int upcb);
    return (mode_base(c.mode, fmb, amb, upcb) + int'(c.ctr)) << gate_log(c.smp);
  endfunction

  function automatic logic window_used(input logic [CODE_W-1:0] win);
    return int'(win) >= WIN_MIN;
  endfunction

  function automatic int window_count(input logic [CODE_W-1:0] win,
                                      input logic [CODE_W-1:0] smp);
    if (!window_used(win)) return 0;
    return 1 << (gate_log(smp) + int'(win) - WIN_MIN);
  endfunction
endpackage

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
  parameter int DIV_W = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       advance,
  input  logic [DIV_W-1:0]           tim_div,
  input  logic [ifc_pkg::CODE_W-1:0] smp_code,
  output logic                       gate_close
);
  localparam int TICK_W = ifc_pkg::GLOG_MAX;

  logic [DIV_W-1:0]  tb_q;
  logic [TICK_W-1:0] tk_q;
  logic              base_tick;
  logic              last_tick;

  assign base_tick  = advance && (tb_q >= tim_div);
  assign last_tick  = (tk_q == TICK_W'((32'd1 << ifc_pkg::gate_log(smp_code)) - 32'd1));
  assign gate_close = base_tick && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0;
      tk_q <= '0;
    end else if (clear) begin
      tb_q <= '0;
      tk_q <= '0;
    end else if (advance) begin
      if (base_tick) begin
        tb_q <= '0;
        tk_q <= gate_close ? '0 : tk_q + TICK_W'(1);
      end else begin
        tb_q <= tb_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/ifc_down_counter.sv
module ifc_down_counter #(
  parameter int SW = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 load,
  input  logic signed [SW-1:0] load_val,
  input  logic                 dec,
  output logic signed [SW-1:0] residual
);
  localparam logic signed [SW-1:0] FLOOR = {1'b1, {(SW-1){1'b0}}};

  logic signed [SW-1:0] cnt_q;
  logic                 step;

  // saturate at the most negative value so a flood of pulses cannot wrap
  assign step     = dec && (cnt_q != FLOOR);
  assign residual = step ? cnt_q - SW'(1) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else             cnt_q <= residual;
  end
endmodule

// File: rtl/ifc_window_judge.sv
module ifc_window_judge #(
  parameter int SW = 22
) (
  input  logic signed [SW-1:0] residual,
  input  logic        [SW-1:0] tol,
  input  logic                 used,
  output logic                 pass
);
  logic signed [SW:0] r_ext;
  logic signed [SW:0] t_ext;

  assign r_ext = {residual[SW-1], residual};
  assign t_ext = {1'b0, tol};
  assign pass  = used && (r_ext <= t_ext) && (r_ext >= -t_ext);
endmodule

// File: rtl/ifc_window_counter.sv
module ifc_window_counter #(
  parameter int DIV_W    = 14,
  parameter int CNT_W    = 21,
  parameter int FM_BASE  = 1696,
  parameter int AM_BASE  = 448,
  parameter int UPC_BASE = 10688
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic [ifc_pkg::MODE_W-1:0] mode,
  input  logic [DIV_W-1:0]           tim_div,
  input  logic [ifc_pkg::CODE_W-1:0] win_code,
  input  logic [ifc_pkg::CODE_W-1:0] smp_code,
  input  logic [ifc_pkg::CTR_W-1:0]  ctr_code,
  input  logic                       if_pulse,
  output logic                       stop_flag,
  output logic                       meas_done
);
  import ifc_pkg::*;

  localparam int SW = CNT_W + 1;

  ifc_cfg_t             cfg_now, cfg_q;
  logic                 run;
  logic                 idle;
  logic                 cfg_chg;
  logic                 load_ev;
  logic                 count_en;
  logic                 gate_close;
  logic                 pass;
  logic signed [SW-1:0] load_val;
  logic signed [SW-1:0] residual;
  logic        [SW-1:0] tol;
  logic                 flag_q, done_q;

  assign cfg_now  = '{mode: mode, win: win_code, smp: smp_code, ctr: ctr_code};
  assign idle     = !enable || (mode == IFM_OFF);
  assign cfg_chg  = run && (cfg_now != cfg_q);
  assign load_ev  = !idle && (!run || cfg_chg);
  assign count_en = !idle && run && !cfg_chg;

  assign load_val = $signed(SW'(expected_count(cfg_now, FM_BASE, AM_BASE, UPC_BASE)));
  assign tol      = SW'(window_count(win_code, smp_code));

  ifc_gate_timer #(.DIV_W(DIV_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (idle || load_ev),
    .advance    (count_en),
    .tim_div    (tim_div),
    .smp_code   (smp_code),
    .gate_close (gate_close)
  );

  ifc_down_counter #(.SW(SW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (idle),
    .load     (load_ev || gate_close),
    .load_val (load_val),
    .dec      (count_en && if_pulse),
    .residual (residual)
  );

  ifc_window_judge #(.SW(SW)) u_judge (
    .residual (residual),
    .tol      (tol),
    .used     (window_used(win_code)),
    .pass     (pass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      run    <= 1'b0;
      flag_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cfg_q <= cfg_now;
      if (idle) begin
        run    <= 1'b0;
        flag_q <= 1'b0;
        done_q <= 1'b0;
      end else if (load_ev) begin
        run    <= 1'b1;
        flag_q <= 1'b0;
        done_q <= 1'b0;
      end else begin
        done_q <= gate_close;
        if (gate_close) flag_q <= pass;
      end
    end
  end

  assign stop_flag = flag_q;
  assign meas_done = done_q;
endmodule

// File: rtl/ifc_window_counter_chk.sv
module ifc_window_counter_chk #(
  parameter int DIV_W = 14
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [DIV_W-1:0]           tim_div,
  input logic [ifc_pkg::CODE_W-1:0] smp_code,
  input logic                       stop_flag,
  input logic                       meas_done,
  input logic                       gate_close,
  input logic                       load_ev,
  input logic                       idle,
  input logic                       cfg_chg,
  input logic                       run
);
  logic [31:0] gl_cnt;
  logic [31:0] gl_want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             gl_cnt <= '0;
    else if (idle || load_ev || gate_close) gl_cnt <= '0;
    else if (run)                           gl_cnt <= gl_cnt + 32'd1;
  end

  assign gl_want = ((32'(tim_div) + 32'd1) << (3'd7 - smp_code)) - 32'd1;

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (!meas_done && !stop_flag)); // R1
  AST_GATE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    gate_close |-> (gl_cnt == gl_want)); // R2
  AST_DONE_FROM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> $past(gate_close)); // R6
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stop_flag) |-> (meas_done || $past(load_ev) || $past(idle))); // R6
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!meas_done && !stop_flag)); // R7
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (!meas_done && !stop_flag)); // R8
endmodule

bind ifc_window_counter ifc_window_counter_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tim_div    (tim_div),
  .smp_code   (smp_code),
  .stop_flag  (stop_flag),
  .meas_done  (meas_done),
  .gate_close (gate_close),
  .load_ev    (load_ev),
  .idle       (idle),
  .cfg_chg    (cfg_chg),
  .run        (run)
);

// File: tb/sim_ifc_window_counter.sv
module sim_ifc_window_counter;
  localparam int P    = 128;
  localparam int FMB  = 40;
  localparam int AMB  = 20;
  localparam int UPCB = 60;
  localparam int NV   = 14;

  typedef struct packed {
    logic [1:0] m;
    logic [2:0] w;
    logic [2:0] s;
    logic [4:0] c;
    logic [7:0] x;
    logic       e;
  } vec_t;

  // mode, window, sample, center, pulses per 128 cycles, expected flag
  localparam vec_t VECS [NV] = '{
    '{2'b01, 3'd3, 3'd7, 5'd0,  8'd40, 1'b1},
    '{2'b01, 3'd3, 3'd7, 5'd0,  8'd41, 1'b1},
    '{2'b01, 3'd3, 3'd7, 5'd0,  8'd42, 1'b0},
    '{2'b01, 3'd3, 3'd7, 5'd0,  8'd38, 1'b0},
    '{2'b10, 3'd4, 3'd7, 5'd5,  8'd27, 1'b1},
    '{2'b10, 3'd4, 3'd7, 5'd5,  8'd28, 1'b0},
    '{2'b11, 3'd7, 3'd6, 5'd31, 8'd75, 1'b1},
    '{2'b11, 3'd7, 3'd6, 5'd31, 8'd74, 1'b0},
    '{2'b10, 3'd5, 3'd5, 5'd0,  8'd24, 1'b1},
    '{2'b10, 3'd5, 3'd5, 5'd0,  8'd25, 1'b0},
    '{2'b01, 3'd1, 3'd7, 5'd0,  8'd40, 1'b0},
    '{2'b01, 3'd2, 3'd7, 5'd0,  8'd40, 1'b0},
    '{2'b01, 3'd6, 3'd7, 5'd10, 8'd58, 1'b1},
    '{2'b01, 3'd6, 3'd7, 5'd10, 8'd59, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [1:0] mode;
  logic [13:0] tim_div;
  logic [2:0] win_code, smp_code;
  logic [4:0] ctr_code;
  logic       if_pulse = 1'b0;
  logic       stop_flag, meas_done;

  int checks = 0;
  int errors = 0;
  int x_rate = 0;
  int ph = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  ifc_window_counter #(.FM_BASE(FMB), .AM_BASE(AMB), .UPC_BASE(UPCB)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .tim_div(tim_div),
    .win_code(win_code), .smp_code(smp_code), .ctr_code(ctr_code),
    .if_pulse(if_pulse), .stop_flag(stop_flag), .meas_done(meas_done)
  );

  // periodic IF pattern: x_rate pulses in every P cycles
  always @(negedge clk) begin
    ph = (ph + 1) % P;
    if_pulse = (ph < x_rate);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n = n + 1;
    end while (!meas_done && n < 40000);
  endtask

  task automatic apply(input vec_t v);
    mode = v.m; win_code = v.w; smp_code = v.s; ctr_code = v.c; x_rate = int'(v.x);
  endtask

  initial begin
    int n, n2, bad;
    rst_n = 1'b0; enable = 1'b0; mode = 2'b00; tim_div = 14'(P - 1);
    win_code = 3'd3; smp_code = 3'd7; ctr_code = 5'd0;
    repeat (5) @(negedge clk);
    check(!stop_flag && !meas_done, "R8 reset outputs", {stop_flag, meas_done}, 0);
    rst_n = 1'b1;

    // R1: standby via enable, then via mode 00
    mode = 2'b01; x_rate = 40;
    bad = 0;
    repeat (600) begin @(negedge clk); if (meas_done || stop_flag) bad++; end
    check(bad == 0, "R1 enable low quiet", bad, 0);
    enable = 1'b1; mode = 2'b00;
    bad = 0;
    repeat (600) begin @(negedge clk); if (meas_done || stop_flag) bad++; end
    check(bad == 0, "R1 mode 00 quiet", bad, 0);

    // R2: first strobe G+1 falling edges after activation
    mode = 2'b01;
    wait_done(n);
    check(n == P + 1, "R2 first gate timing", n, P + 1);

    // R3 R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      wait_done(n);
      wait_done(n2);
      check(n2 == (P << (7 - int'(VECS[i].s))), "R2 gate length", n2, P << (7 - int'(VECS[i].s)));
      if (VECS[i].w < 3)
        check(stop_flag == VECS[i].e, $sformatf("R5 vector %0d", i), stop_flag, VECS[i].e);
      else
        check(stop_flag == VECS[i].e, $sformatf("R3/R4 vector %0d", i), stop_flag, VECS[i].e);
    end

    // R6: flag holds through the following gate, strobe lasts one cycle
    apply('{2'b01, 3'd3, 3'd7, 5'd0, 8'd40, 1'b1});
    wait_done(n); wait_done(n);
    check(stop_flag == 1'b1, "R6 pass before hold", stop_flag, 1);
    x_rate = 45;
    @(negedge clk);
    check(!meas_done, "R6 strobe width", meas_done, 0);
    bad = 0;
    while (!meas_done) begin
      if (stop_flag != 1'b1) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R6 flag held", bad, 0);
    check(stop_flag == 1'b0, "R6 new verdict", stop_flag, 0);

    // R7: change center mid gate
    x_rate = 40;
    wait_done(n); wait_done(n);
    check(stop_flag == 1'b1, "R7 pass before abort", stop_flag, 1);
    repeat (50) @(negedge clk);
    ctr_code = 5'd1;
    @(negedge clk);
    check(stop_flag == 1'b0, "R7 flag cleared", stop_flag, 0);
    wait_done(n);
    check(n == P, "R7 restart length", n, P);
    check(stop_flag == 1'b1, "R7 verdict after restart", stop_flag, 1);

    // R7: change mode mid gate
    repeat (30) @(negedge clk);
    mode = 2'b10;
    wait_done(n);
    check(n == P + 1, "R7 mode change restart", n, P + 1);
    check(stop_flag == 1'b0, "R7 AM verdict", stop_flag, 0);

    // R2: longest gate
    apply('{2'b01, 3'd3, 3'd0, 5'd0, 8'd40, 1'b1});
    wait_done(n); wait_done(n2);
    check(n2 == P * 128, "R2 longest gate", n2, P * 128);
    check(stop_flag == 1'b1, "R4 longest gate verdict", stop_flag, 1);

    // R1: drop enable while running
    enable = 1'b0;
    @(negedge clk);
    bad = 0;
    repeat (400) begin if (meas_done || stop_flag) bad++; @(negedge clk); end
    check(bad == 0, "R1 standby mid run", bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule